// File: doc/BRIEF.md
# Run-Length Sparse Column Weight Decoder

This block walks the stored nonzero entries of a single column of a compressed sparse matrix and turns each one into a decoded weight paired with the absolute row it belongs to. Every entry is one byte that carries a 4-bit weight code and a 4-bit count of zero rows skipped ahead of it. The code selects one of sixteen shared 16-bit fixed-point weights from a codebook. An entry with code 0 is padding: it only moves the row position forward, which lets gaps longer than fifteen rows be encoded.

A caller presents a column number while the decoder is idle. The decoder reads that column's start pointer and the next column's start pointer from a pointer memory, streams the entries in between out of an entry memory, and offers each decoded (weight, row) pair on a valid/ready output. When the column is used up it raises a one-cycle done pulse. The pointer and entry memories have synchronous reads with one cycle of latency. The codebook is read combinationally. All three memories live outside the block and are filled by the surrounding system.

Top module: `sparse_col_decoder`

## Requirements
- R1: An entry byte holds the weight code in bits [7:4] and the zero count in bits [3:0].
- R2: A request for column j reads pointer memory addresses j and j+1 and then reads entry addresses p[j] up to p[j+1]-1 in ascending order, never outside that span. Both memories return data one cycle after the read enable.
- R3: The first entry of a column sits at row equal to its zero count. Every later entry sits at the previous entry's row plus its zero count plus one.
- R4: The output weight of an entry is the 16-bit codebook value selected by its weight code.
- R5: An entry with weight code 0 produces no output. It still advances the row position, so a padding entry with zero count 15 moves the row by 16.
- R6: A column with p[j+1] equal to p[j] produces no output and ends with a done pulse within three cycles of acceptance.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_weight and out_row hold their values. No pair is lost or repeated.
- R8: done is a one-cycle pulse that follows the last output handshake or the last padding entry of the column. It is never high together with out_valid.
- R9: col_req_ready is high only when the decoder is idle, and a request raised while it is low is ignored.
- R10: After synchronous reset, out_valid and done are low and col_req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_req_valid | input | 1 | Column request strobe |
| col_req_idx | input | COL_W | Column number requested |
| col_req_ready | output | 1 | High when a request can be taken (idle) |
| ptr_rd_en | output | 1 | Pointer memory read enable |
| ptr_rd_addr | output | COL_W+1 | Pointer memory read address |
| ptr_rd_data | input | ENT_AW | Pointer memory read data, one cycle after enable |
| ent_rd_en | output | 1 | Entry memory read enable |
| ent_rd_addr | output | ENT_AW | Entry memory read address |
| ent_rd_data | input | 8 | Entry byte, one cycle after enable |
| cb_rd_addr | output | 4 | Codebook index (the current entry's weight code) |
| cb_rd_data | input | WGT_W | Codebook weight, combinational |
| out_valid | output | 1 | Decoded pair available |
| out_ready | input | 1 | Consumer accepts the pair |
| out_weight | output | WGT_W | Decoded weight |
| out_row | output | ROW_W | Absolute row index of the weight |
| done | output | 1 | One-cycle pulse when the column is finished |

## Verification
A corrupted row register or a lost first-entry flag shows up at the first output of the next column as a wrong out_row, and the scoreboard flags it on that handshake. A wrong entry pointer or end bound shows up as a missing, extra or shifted pair, or as a done pulse that arrives while expected pairs are still queued, within one entry time. A broken stall path shows up one cycle after out_ready drops, as a changed weight or row or a dropped valid. A request that slips in while the decoder is busy produces unexpected pairs after the done pulse.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int CODE_W = 4;
  localparam int ZRUN_W = 4;
  localparam int ENT_W  = CODE_W + ZRUN_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLO,
    ST_PHI,
    ST_DEC,
    ST_HOLD
  } walk_state_t;

  function automatic logic [CODE_W-1:0] ent_code(input logic [ENT_W-1:0] e);
    return e[ENT_W-1:ZRUN_W];
  endfunction

  function automatic logic [ZRUN_W-1:0] ent_zrun(input logic [ENT_W-1:0] e);
    return e[ZRUN_W-1:0];
  endfunction
endpackage

// File: rtl/scd_row_calc.sv
module scd_row_calc #(
  parameter int ROW_W  = 12,
  parameter int ZRUN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  input  logic [ZRUN_W-1:0] zrun,
  output logic [ROW_W-1:0]  row_next,
  output logic [ROW_W-1:0]  row_q
);
  localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);
  localparam logic [ROW_W-1:0] ROW_SAFE = {1'b0, {(ROW_W-1){1'b1}}};

  logic first_q;

  always_comb begin
    if (first_q) row_next = ROW_W'(zrun);
    else         row_next = row_q + ROW_W'(zrun) + ROW_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      row_q   <= '0;
    end else if (clear) begin
      first_q <= 1'b1;
      row_q   <= '0;
    end else if (advance) begin
      first_q <= 1'b0;
      row_q   <= row_next;
    end
  end

  // R3: inside a column the row position strictly grows with each entry
  assert_row_grows_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear && !first_q && row_q < ROW_SAFE) |=> (row_q > $past(row_q)));
endmodule

// File: rtl/scd_out_stage.sv
module scd_out_stage #(
  parameter int WGT_W = 16,
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WGT_W-1:0] load_weight,
  input  logic [ROW_W-1:0] load_row,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WGT_W-1:0] out_weight,
  output logic [ROW_W-1:0] out_row,
  output logic             fire
);
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_weight <= '0;
      out_row    <= '0;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_weight <= load_weight;
      out_row    <= load_row;
    end else if (fire) begin
      out_valid  <= 1'b0;
    end
  end

  // R7: a stalled pair stays put
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_weight) && $stable(out_row)));

  // R7: a new pair is never loaded over one still pending
  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
    load |-> !out_valid);
endmodule

// File: rtl/sparse_col_decoder.sv
module sparse_col_decoder
  import scd_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int ENT_AW = 8,
  parameter int WGT_W  = 16,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              col_req_valid,
  input  logic [COL_W-1:0]  col_req_idx,
  output logic              col_req_ready,
  output logic              ptr_rd_en,
  output logic [COL_W:0]    ptr_rd_addr,
  input  logic [ENT_AW-1:0] ptr_rd_data,
  output logic              ent_rd_en,
  output logic [ENT_AW-1:0] ent_rd_addr,
  input  logic [7:0]        ent_rd_data,
  output logic [3:0]        cb_rd_addr,
  input  logic [WGT_W-1:0]  cb_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WGT_W-1:0]  out_weight,
  output logic [ROW_W-1:0]  out_row,
  output logic              done
);
  localparam int PA_W = COL_W + 1;

  walk_state_t       state_q, state_d;
  logic [PA_W-1:0]   col_q;
  logic [ENT_AW-1:0] cur_q, end_q, cur_inc;
  logic              done_d;
  logic              emit, last_dec, row_clear, row_adv, fire;
  logic [CODE_W-1:0] code;
  logic [ZRUN_W-1:0] zrun;
  logic [ROW_W-1:0]  row_next, row_q;

  assign code     = ent_code(ent_rd_data);
  assign zrun     = ent_zrun(ent_rd_data);
  assign cur_inc  = cur_q + ENT_AW'(1);
  assign last_dec = (cur_inc == end_q);
  assign emit     = (state_q == ST_DEC) && (code != '0);
  assign row_adv  = (state_q == ST_DEC);
  assign row_clear = (state_q == ST_IDLE);
  assign cb_rd_addr = code;
  assign col_req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    done_d      = 1'b0;
    ptr_rd_en   = 1'b0;
    ptr_rd_addr = col_q;
    ent_rd_en   = 1'b0;
    ent_rd_addr = cur_q;
    unique case (state_q)
      ST_IDLE: begin
        ptr_rd_addr = PA_W'(col_req_idx);
        if (col_req_valid) begin
          ptr_rd_en = 1'b1;
          state_d   = ST_PLO;
        end
      end
      ST_PLO: begin
        ptr_rd_en   = 1'b1;
        ptr_rd_addr = col_q + PA_W'(1);
        state_d     = ST_PHI;
      end
      ST_PHI: begin
        if (ptr_rd_data == cur_q) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          ent_rd_en = 1'b1;
          state_d   = ST_DEC;
        end
      end
      ST_DEC: begin
        if (code != '0) begin
          state_d = ST_HOLD;
        end else if (last_dec) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          ent_rd_en   = 1'b1;
          ent_rd_addr = cur_inc;
        end
      end
      ST_HOLD: begin
        if (fire) begin
          if (cur_q == end_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            ent_rd_en = 1'b1;
            state_d   = ST_DEC;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      cur_q   <= '0;
      end_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      if (state_q == ST_IDLE && col_req_valid) col_q <= PA_W'(col_req_idx);
      if (state_q == ST_PLO) cur_q <= ptr_rd_data;
      if (state_q == ST_PHI) end_q <= ptr_rd_data;
      if (state_q == ST_DEC) cur_q <= cur_inc;
    end
  end

  scd_row_calc #(
    .ROW_W (ROW_W),
    .ZRUN_W(ZRUN_W)
  ) u_row (
    .clk     (clk),
    .rst     (rst),
    .clear   (row_clear),
    .advance (row_adv),
    .zrun    (zrun),
    .row_next(row_next),
    .row_q   (row_q)
  );

  scd_out_stage #(
    .WGT_W(WGT_W),
    .ROW_W(ROW_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .load       (emit),
    .load_weight(cb_rd_data),
    .load_row   (row_next),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_weight (out_weight),
    .out_row    (out_row),
    .fire       (fire)
  );

  // R2: entries are only decoded while the pointer is inside the column span
  assert_dec_in_span_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEC) |-> (cur_q < end_q));

  // R8: done never coincides with a pending pair
  assert_done_no_valid_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  // R8: done lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: an idle decoder has nothing pending at its output
  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
    col_req_ready |-> !out_valid);
endmodule

// File: tb/sparse_col_decoder_tb.sv
module sparse_col_decoder_tb;
  localparam int COL_W  = 6;
  localparam int ENT_AW = 8;
  localparam int WGT_W  = 16;
  localparam int ROW_W  = 12;

  logic              clk = 1'b0;
  logic              rst;
  logic              col_req_valid;
  logic [COL_W-1:0]  col_req_idx;
  logic              col_req_ready;
  logic              ptr_rd_en;
  logic [COL_W:0]    ptr_rd_addr;
  logic [ENT_AW-1:0] ptr_rd_data;
  logic              ent_rd_en;
  logic [ENT_AW-1:0] ent_rd_addr;
  logic [7:0]        ent_rd_data;
  logic [3:0]        cb_rd_addr;
  logic [WGT_W-1:0]  cb_rd_data;
  logic              out_valid;
  logic              out_ready;
  logic [WGT_W-1:0]  out_weight;
  logic [ROW_W-1:0]  out_row;
  logic              done;

  logic [ENT_AW-1:0] ptr_mem [0:127];
  logic [7:0]        ent_mem [0:255];
  logic [WGT_W-1:0]  cb_mem  [0:15];

  logic [WGT_W-1:0]  exp_w [$];
  logic [ROW_W-1:0]  exp_r [$];

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int ready_mode = 0;
  int tick = 0;
  logic             prev_stall = 1'b0;
  logic [WGT_W-1:0] prev_w;
  logic [ROW_W-1:0] prev_r;

  always #4 clk = ~clk;

  sparse_col_decoder #(
    .COL_W(COL_W), .ENT_AW(ENT_AW), .WGT_W(WGT_W), .ROW_W(ROW_W)
  ) u_dut (
    .clk(clk), .rst(rst),
    .col_req_valid(col_req_valid), .col_req_idx(col_req_idx), .col_req_ready(col_req_ready),
    .ptr_rd_en(ptr_rd_en), .ptr_rd_addr(ptr_rd_addr), .ptr_rd_data(ptr_rd_data),
    .ent_rd_en(ent_rd_en), .ent_rd_addr(ent_rd_addr), .ent_rd_data(ent_rd_data),
    .cb_rd_addr(cb_rd_addr), .cb_rd_data(cb_rd_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_weight(out_weight), .out_row(out_row), .done(done)
  );

  always @(posedge clk) begin
    if (ptr_rd_en) ptr_rd_data <= ptr_mem[ptr_rd_addr];
    if (ent_rd_en) ent_rd_data <= ent_mem[ent_rd_addr];
  end
  assign cb_rd_data = cb_mem[cb_rd_addr];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ready patterns
  always @(negedge clk) begin
    tick++;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = tick[0];
      default: out_ready = ((tick % 7) >= 5);
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (prev_stall) begin
        check(out_valid == 1'b1, "R7", "valid dropped in stall", out_valid, 1);
        check(out_weight == prev_w && out_row == prev_r, "R7", "stalled pair changed",
              {out_weight, out_row}, {prev_w, prev_r});
      end
      if (out_valid && out_ready) begin
        if (exp_w.size() == 0) begin
          check(1'b0, "R9", "unexpected pair", {out_weight, out_row}, 0);
        end else begin
          logic [WGT_W-1:0] ew;
          logic [ROW_W-1:0] er;
          ew = exp_w.pop_front();
          er = exp_r.pop_front();
          check(out_weight == ew, "R4", "weight", out_weight, ew);
          check(out_row == er, "R3", "row", out_row, er);
        end
      end
      if (done) begin
        done_cnt++;
        check(exp_w.size() == 0, "R8", "done with pairs still expected", exp_w.size(), 0);
      end
      prev_stall = out_valid && !out_ready;
      prev_w = out_weight;
      prev_r = out_row;
    end
  end

  // expected stream from the requirements (R1, R3, R4, R5)
  task automatic push_expected(input int j);
    int row = 0;
    bit first = 1;
    for (int a = ptr_mem[j]; a < ptr_mem[j+1]; a++) begin
      int code = ent_mem[a][7:4];
      int zr   = ent_mem[a][3:0];
      row = first ? zr : row + zr + 1;
      first = 0;
      if (code != 0) begin
        exp_w.push_back(cb_mem[code]);
        exp_r.push_back(ROW_W'(row));
      end
    end
  endtask

  task automatic issue(input int j);
    @(negedge clk);
    while (!col_req_ready) @(negedge clk);
    push_expected(j);
    col_req_valid = 1'b1;
    col_req_idx   = COL_W'(j);
    @(negedge clk);
    col_req_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    int start = done_cnt;
    n = 0;
    while (done_cnt == start && n < 3000) begin
      @(negedge clk);
      #2;
      n++;
    end
  endtask

  initial begin
    int n;
    int dc;
    for (int i = 0; i < 16; i++) cb_mem[i] = (i == 0) ? 16'h0 : 16'h0A00 + 16'(i * 16'h0111);
    for (int i = 0; i < 256; i++) ent_mem[i] = 8'h00;
    // R1 layout: {code, zeros}
    ent_mem[0] = 8'h32; ent_mem[1] = 8'h50; ent_mem[2] = 8'h14;
    ent_mem[3] = 8'h0F; ent_mem[4] = 8'h73; ent_mem[5] = 8'h0F; ent_mem[6] = 8'h0F; ent_mem[7] = 8'h20;
    ent_mem[8] = 8'hF0; ent_mem[9] = 8'h8F; ent_mem[10] = 8'h07;
    for (int k = 0; k < 20; k++)
      ent_mem[11+k] = {((k % 4) == 0) ? 4'd0 : 4'(k % 16), 4'((k * 7) % 16)};
    for (int i = 0; i < 128; i++) ptr_mem[i] = 8'd31;
    ptr_mem[0] = 0; ptr_mem[1] = 3; ptr_mem[2] = 3; ptr_mem[3] = 8; ptr_mem[4] = 11; ptr_mem[5] = 31;

    rst = 1'b1; col_req_valid = 1'b0; col_req_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(done == 1'b0, "R10", "done after reset", done, 0);
    check(col_req_ready == 1'b1, "R10", "ready after reset", col_req_ready, 1);

    // R3 R4: plain column, ready always high
    ready_mode = 0;
    issue(0); wait_done(n);
    check(n < 3000, "R8", "done for column 0", n, 0);

    // R6: empty column
    dc = done_cnt;
    issue(1); wait_done(n);
    check(n <= 3, "R6", "empty column done latency", n, 3);
    check(done_cnt == dc + 1, "R6", "single done pulse", done_cnt, dc + 1);

    // R5: padding entries, alternating ready
    ready_mode = 1;
    issue(2); wait_done(n);
    check(n < 3000, "R5", "done for padded column", n, 0);

    // R5 R8: column ending in padding, long stalls (R7)
    ready_mode = 2;
    issue(3); wait_done(n);
    check(n < 3000, "R8", "done after trailing padding", n, 0);

    // R9: long column, a second request while busy must be ignored
    issue(4);
    repeat (4) @(negedge clk);
    check(col_req_ready == 1'b0, "R9", "ready while busy", col_req_ready, 0);
    col_req_valid = 1'b1; col_req_idx = 0;
    @(negedge clk);
    col_req_valid = 1'b0;
    wait_done(n);
    check(n < 3000, "R2", "done for long column", n, 0);
    repeat (20) @(negedge clk);
    check(exp_w.size() == 0, "R2", "all expected pairs seen", exp_w.size(), 0);
    check(col_req_ready == 1'b1, "R9", "idle after ignored request", col_req_ready, 1);

    // R3: row restarts at the next column
    ready_mode = 0;
    issue(0); wait_done(n);
    repeat (3) @(negedge clk);
    check(exp_w.size() == 0, "R3", "rerun column drained", exp_w.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule